// File: doc/BRIEF.md
# Trace Trigger Byte Countdown

This block sets how many more bytes of trace are captured once a trigger has been seen, and then signals the end of that window. Software loads a post-trigger byte budget through a 64-bit register port and can read the live value back at any time. A one-cycle trigger-seen pulse arms the counter. From then on, every trace beat written to the buffer while the capture qualifier is high subtracts its byte count from the budget. Once the budget is used up, the block emits a single-cycle trigger-event pulse and disarms itself.

Only the low 32 bits of the register hold the count. The upper half reads as zero. A parameter sets how finely the count is aligned: the count is kept in units of 2^ALIGN_BITS bytes, so those low bits always read as zero and are dropped both on load and from each beat's byte count. A write-block input lets surrounding logic discard a register write. A write that lands in the same cycle as a decrement wins over the decrement.

Top module: `trace_trig_countdown`

## Requirements
- R1: `sw_rd_data[63:32]` always reads zero, whatever value was written to those bits. `sw_rd_data[31:0]` shows the current count.
- R2: A write with `sw_wr_en` high and `sw_wr_block` low loads `sw_wr_data[31:0]` with the low ALIGN_BITS bits (default 2) cleared. The new value is visible on `sw_rd_data` after the next clock edge.
- R3: A write with `sw_wr_block` high is discarded, and the count keeps its previous value.
- R4: Before the block is armed, beats do not change the count. A `trig_seen` pulse while disarmed sets `armed` high after the next edge.
- R5: While the block is armed, a cycle with `beat_valid` and `capture_qual` both high lowers the count by `beat_bytes`, with the low ALIGN_BITS bits of `beat_bytes` ignored. The change shows after the next edge. If either input is low, the count does not change.
- R6: The count saturates at zero. A beat larger than the remaining count leaves zero and never wraps.
- R7: A cycle with the block armed, the count at zero and no load raises `trig_event` for exactly one cycle after the next edge. `armed` drops at that same edge, and later beats leave the count alone.
- R8: A load in the same cycle as a qualifying beat, or in the same cycle as a zero-count event condition, takes effect alone. No decrement is applied and no event is raised in that cycle.
- R9: Reset clears the count to zero, leaves the block disarmed and holds `trig_event` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Register write strobe |
| sw_wr_block | input | 1 | Discard the write in this cycle |
| sw_wr_data | input | 64 | Register write value |
| sw_rd_data | output | 64 | Register read value |
| trig_seen | input | 1 | Trigger-detected pulse; arms the countdown |
| beat_valid | input | 1 | A trace beat is written to the buffer in this cycle |
| beat_bytes | input | 5 | Bytes in this beat (0 to 16) |
| capture_qual | input | 1 | Qualifying condition for counting |
| armed | output | 1 | The countdown is armed |
| trig_event | output | 1 | One-cycle pulse when the budget runs out |

## Verification
The stored budget is visible on the read port, so a wrong decrement, a wrong alignment mask or a missed load shows up there one edge after the offending cycle. A fault in the arm state shows either as a count that moves before any trigger, or as an `armed` output that sets or clears on the wrong edge. A fault in event generation shows one edge after the count reaches zero: the `trig_event` pulse is missing, lasts more than one cycle, or fires after a load that should have won that cycle.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
   typedef enum logic {
      TTC_DISARMED = 1'b0,
      TTC_COUNTING = 1'b1
   } ttc_state_e;

   function automatic int ttc_units_width(input int cnt_w, input int align_bits);
      return cnt_w - align_bits;
   endfunction
endpackage

// File: rtl/ttc_reg_port.sv
module ttc_reg_port #(
   parameter int REG_W      = 64,
   parameter int CNT_W      = 32,
   parameter int ALIGN_BITS = 2,
   localparam int UNITS_W   = ttc_pkg::ttc_units_width(CNT_W, ALIGN_BITS)
) (
   input  logic               wr_en,
   input  logic               wr_block,
   input  logic [REG_W-1:0]   wr_data,
   input  logic [CNT_W-1:0]   cnt_now,
   output logic               load,
   output logic [UNITS_W-1:0] load_units,
   output logic [REG_W-1:0]   rd_data
);
   assign load       = wr_en & ~wr_block;
   assign load_units = wr_data[CNT_W-1:ALIGN_BITS];

   if (REG_W > CNT_W) begin : g_wide_reg
      logic unused_hi_bits;
      assign unused_hi_bits = ^wr_data[REG_W-1:CNT_W];
      assign rd_data        = {{(REG_W-CNT_W){1'b0}}, cnt_now};
   end else begin : g_exact_reg
      assign rd_data = cnt_now;
   end

   if (ALIGN_BITS > 0) begin : g_drop_low
      logic unused_lo_bits;
      assign unused_lo_bits = ^wr_data[ALIGN_BITS-1:0];
   end
endmodule

// File: rtl/ttc_counter.sv
module ttc_counter #(
   parameter int CNT_W      = 32,
   parameter int ALIGN_BITS = 2,
   parameter int BEAT_W     = 5,
   localparam int UNITS_W   = ttc_pkg::ttc_units_width(CNT_W, ALIGN_BITS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [UNITS_W-1:0] load_units,
   input  logic               dec_en,
   input  logic [BEAT_W-1:0]  dec_bytes,
   output logic [CNT_W-1:0]   cnt,
   output logic               cnt_zero
);
   logic [UNITS_W-1:0] units_q;
   logic [UNITS_W-1:0] step_units;
   logic [UNITS_W-1:0] units_dec;

   assign step_units = UNITS_W'(dec_bytes >> ALIGN_BITS);
   assign units_dec  = (step_units >= units_q) ? '0 : (units_q - step_units);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         units_q <= '0;
      end else if (load) begin
         units_q <= load_units;
      end else if (dec_en) begin
         units_q <= units_dec;
      end
   end

   if (ALIGN_BITS > 0) begin : g_aligned
      assign cnt = {units_q, {ALIGN_BITS{1'b0}}};
   end else begin : g_bytewise
      assign cnt = units_q;
   end

   assign cnt_zero = (units_q == '0);

   assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt[CNT_W-1:ALIGN_BITS] == $past(load_units)));

   assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_en && !load) |=> (cnt <= $past(cnt)));

   assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec_en && !load) |=> $stable(cnt));
endmodule

// File: rtl/ttc_event_ctl.sv
module ttc_event_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_seen,
   input  logic cnt_zero,
   input  logic load,
   output logic armed,
   output logic trig_event
);
   import ttc_pkg::*;

   ttc_state_e state_q, state_d;
   logic       expire;
   logic       event_q;

   assign expire = (state_q == TTC_COUNTING) && cnt_zero && !load;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         TTC_DISARMED: if (trig_seen) state_d = TTC_COUNTING;
         TTC_COUNTING: if (expire)    state_d = TTC_DISARMED;
         default:                     state_d = TTC_DISARMED;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= TTC_DISARMED;
         event_q <= 1'b0;
      end else begin
         state_q <= state_d;
         event_q <= expire;
      end
   end

   assign armed      = (state_q == TTC_COUNTING);
   assign trig_event = event_q;

   assert_event_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      trig_event |=> !trig_event);

   assert_event_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
      trig_event |-> !armed);

   assert_arm_on_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && trig_seen) |=> armed);

   assert_load_beats_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !trig_event);
endmodule

// File: rtl/trace_trig_countdown.sv
module trace_trig_countdown #(
   parameter int REG_W          = 64,
   parameter int CNT_W          = 32,
   parameter int ALIGN_BITS     = 2,
   parameter int MAX_BEAT_BYTES = 16,
   localparam int BEAT_W        = $clog2(MAX_BEAT_BYTES + 1),
   localparam int UNITS_W       = ttc_pkg::ttc_units_width(CNT_W, ALIGN_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_wr_en,
   input  logic              sw_wr_block,
   input  logic [REG_W-1:0]  sw_wr_data,
   output logic [REG_W-1:0]  sw_rd_data,
   input  logic              trig_seen,
   input  logic              beat_valid,
   input  logic [BEAT_W-1:0] beat_bytes,
   input  logic              capture_qual,
   output logic              armed,
   output logic              trig_event
);
   if (CNT_W > REG_W) begin : g_bad_cnt_w
      $error("CNT_W must not exceed REG_W");
   end
   if (ALIGN_BITS < 0 || ALIGN_BITS >= CNT_W) begin : g_bad_align
      $error("ALIGN_BITS must lie in [0, CNT_W)");
   end
   if ((MAX_BEAT_BYTES % (1 << ALIGN_BITS)) != 0) begin : g_bad_beat
      $error("MAX_BEAT_BYTES must be a multiple of the alignment granule");
   end
   if (BEAT_W >= UNITS_W) begin : g_bad_beat_w
      $error("beat byte field too wide for the count");
   end

   logic               load;
   logic [UNITS_W-1:0] load_units;
   logic [CNT_W-1:0]   cnt;
   logic               cnt_zero;
   logic               dec_en;

   ttc_reg_port #(.REG_W(REG_W), .CNT_W(CNT_W), .ALIGN_BITS(ALIGN_BITS)) i_reg_port (
      .wr_en      (sw_wr_en),
      .wr_block   (sw_wr_block),
      .wr_data    (sw_wr_data),
      .cnt_now    (cnt),
      .load       (load),
      .load_units (load_units),
      .rd_data    (sw_rd_data)
   );

   assign dec_en = armed & beat_valid & capture_qual;

   ttc_counter #(.CNT_W(CNT_W), .ALIGN_BITS(ALIGN_BITS), .BEAT_W(BEAT_W)) i_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_units (load_units),
      .dec_en     (dec_en),
      .dec_bytes  (beat_bytes),
      .cnt        (cnt),
      .cnt_zero   (cnt_zero)
   );

   ttc_event_ctl i_event_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_seen  (trig_seen),
      .cnt_zero   (cnt_zero),
      .load       (load),
      .armed      (armed),
      .trig_event (trig_event)
   );

   assert_blocked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr_en && sw_wr_block && !armed) |=> $stable(sw_rd_data));

   assert_idle_until_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !(sw_wr_en && !sw_wr_block)) |=> $stable(sw_rd_data));

   assert_write_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr_en && !sw_wr_block) |=>
         (sw_rd_data[CNT_W-1:0] ==
          ($past(sw_wr_data[CNT_W-1:0]) & ~CNT_W'((1 << ALIGN_BITS) - 1))));
endmodule

// File: tb/test_trace_trig_countdown.sv
`timescale 1ns/1ps
module test_trace_trig_countdown;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        sw_wr_en, sw_wr_block;
   logic [63:0] sw_wr_data;
   logic [63:0] sw_rd_data;
   logic        trig_seen, beat_valid, capture_qual;
   logic [4:0]  beat_bytes;
   logic        armed, trig_event;

   int n_checks = 0;
   int n_fails  = 0;

   always #10 clk = ~clk;

   trace_trig_countdown i_trace_trig_countdown (
      .clk(clk), .rst_n(rst_n),
      .sw_wr_en(sw_wr_en), .sw_wr_block(sw_wr_block),
      .sw_wr_data(sw_wr_data), .sw_rd_data(sw_rd_data),
      .trig_seen(trig_seen), .beat_valid(beat_valid),
      .beat_bytes(beat_bytes), .capture_qual(capture_qual),
      .armed(armed), .trig_event(trig_event)
   );

   typedef struct packed {
      logic        wr, blk, det, bv, qual;
      logic [4:0]  nb;
      logic [63:0] wd;
      logic [63:0] exp_rd;
      logic        exp_arm, exp_ev;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b0,1'b0,1'b0,1'b0,5'd0, 64'hFFFF_FFFF_0000_0107, 64'h104, 1'b0,1'b0}, // R2 R1 load, low bits and upper half dropped
      '{1'b1,1'b1,1'b0,1'b0,1'b0,5'd0, 64'h55,                  64'h104, 1'b0,1'b0}, // R3 blocked write
      '{1'b0,1'b0,1'b0,1'b1,1'b1,5'd8, 64'h0,                   64'h104, 1'b0,1'b0}, // R4 beat before arm
      '{1'b0,1'b0,1'b1,1'b0,1'b0,5'd0, 64'h0,                   64'h104, 1'b1,1'b0}, // R4 arm
      '{1'b0,1'b0,1'b0,1'b1,1'b1,5'd8, 64'h0,                   64'hFC,  1'b1,1'b0}, // R5 decrement 8
      '{1'b0,1'b0,1'b0,1'b1,1'b0,5'd8, 64'h0,                   64'hFC,  1'b1,1'b0}, // R5 qualifier low
      '{1'b0,1'b0,1'b0,1'b0,1'b1,5'd8, 64'h0,                   64'hFC,  1'b1,1'b0}, // R5 beat invalid
      '{1'b0,1'b0,1'b0,1'b1,1'b1,5'd7, 64'h0,                   64'hF8,  1'b1,1'b0}, // R5 low beat bits ignored (7 -> 4)
      '{1'b1,1'b0,1'b0,1'b1,1'b1,5'd16,64'h20,                  64'h20,  1'b1,1'b0}, // R8 write beats decrement
      '{1'b0,1'b0,1'b0,1'b1,1'b1,5'd16,64'h0,                   64'h10,  1'b1,1'b0}, // R5 decrement 16
      '{1'b0,1'b0,1'b0,1'b1,1'b1,5'd31,64'h0,                   64'h0,   1'b1,1'b0}, // R6 saturate (28 > 16)
      '{1'b0,1'b0,1'b0,1'b0,1'b0,5'd0, 64'h0,                   64'h0,   1'b0,1'b1}, // R7 event, disarm
      '{1'b0,1'b0,1'b0,1'b0,1'b0,5'd0, 64'h0,                   64'h0,   1'b0,1'b0}, // R7 single cycle
      '{1'b1,1'b0,1'b0,1'b0,1'b0,5'd0, 64'h40,                  64'h40,  1'b0,1'b0}, // R2 reload
      '{1'b0,1'b0,1'b0,1'b1,1'b1,5'd8, 64'h0,                   64'h40,  1'b0,1'b0}, // R7 no count after event
      '{1'b0,1'b0,1'b1,1'b0,1'b0,5'd0, 64'h0,                   64'h40,  1'b1,1'b0}, // R4 re-arm
      '{1'b1,1'b0,1'b0,1'b0,1'b0,5'd0, 64'h0,                   64'h0,   1'b1,1'b0}, // R8 load zero
      '{1'b1,1'b0,1'b0,1'b0,1'b0,5'd0, 64'h8,                   64'h8,   1'b1,1'b0}, // R8 load wins over zero-count event
      '{1'b0,1'b0,1'b0,1'b1,1'b1,5'd8, 64'h0,                   64'h0,   1'b1,1'b0}  // R5 exact to zero
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      sw_wr_en = 0; sw_wr_block = 0; sw_wr_data = '0;
      trig_seen = 0; beat_valid = 0; capture_qual = 0; beat_bytes = '0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      n_fails++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      idle_inputs();
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R9 reset count", sw_rd_data, 64'h0);
      check("R9 reset armed", {63'h0, armed}, 64'h0);
      check("R9 reset event", {63'h0, trig_event}, 64'h0);
      rst_n = 1;

      for (int i = 0; i < NV; i++) begin
         sw_wr_en = VECS[i].wr;  sw_wr_block = VECS[i].blk; sw_wr_data = VECS[i].wd;
         trig_seen = VECS[i].det; beat_valid = VECS[i].bv;
         capture_qual = VECS[i].qual; beat_bytes = VECS[i].nb;
         step();
         check($sformatf("vec%0d count", i), sw_rd_data, VECS[i].exp_rd);
         check($sformatf("vec%0d armed", i), {63'h0, armed}, {63'h0, VECS[i].exp_arm});
         check($sformatf("vec%0d event", i), {63'h0, trig_event}, {63'h0, VECS[i].exp_ev});
      end
      // armed with count zero after vec18: the event follows
      step();
      check("R7 event after exact zero", {63'h0, trig_event}, 64'h1);

      // R1 R2: all-ones write keeps 32 bits, low two cleared
      sw_wr_en = 1; sw_wr_data = '1;
      step();
      check("R1 R2 all-ones load", sw_rd_data, 64'h0000_0000_FFFF_FFFC);

      // R5 long countdown: 0x100 bytes at 16 per beat
      sw_wr_en = 1; sw_wr_data = 64'h100; trig_seen = 1;
      step();
      for (int k = 1; k <= 16; k++) begin
         beat_valid = 1; capture_qual = 1; beat_bytes = 5'd16;
         step();
         check("R5 long countdown", sw_rd_data, 64'(256 - 16 * k));
      end
      check("R7 no event yet", {63'h0, trig_event}, 64'h0);
      step();
      check("R7 event at end", {63'h0, trig_event}, 64'h1);

      // R9 reset mid-run
      sw_wr_en = 1; sw_wr_data = 64'h1000; trig_seen = 1;
      step();
      rst_n = 0;
      step();
      rst_n = 1;
      check("R9 mid-run reset count", sw_rd_data, 64'h0);
      check("R9 mid-run reset armed", {63'h0, armed}, 64'h0);
      finish_run();
   end
endmodule